// File: doc/BRIEF.md
# SMBus Indexed Block Configuration Target

This block is a serial-bus target that gives a host access to a small configuration register file for a two-pair differential clock source. It watches an open-drain clock line and data line and samples both with a much faster system clock. It pulls the data line low to acknowledge bytes and to send read data. Every transfer is indexed and counted. In a write, the host sends a start index and then a byte count, and the data bytes follow. In a read, the host sets the index and then issues a repeated start. The target then returns a byte count, taken from a writable register, and after it the data from the index onward.

The register file drives these fields straight to ports: the output enables, the slew selects and the amplitude of the two clock pairs, the spread mode, and the reference-output controls. A read-only spread code comes in from pins that were latched at power-up. It is read back, and it decides the spread mode until software takes control. An address-select input is captured while reset is held and picks one of two bus addresses.

Top module: `smb_cfg_slave`

## Requirements
- R1: The target answers only to the 7-bit address 0x68 when `addr_sel` was 0 during reset, or 0x6A when it was 1. The level of `addr_sel` is captured while `rst` is high. Any other address is not acknowledged, and the bytes that follow it have no effect until the next start.
- R2: The target changes `sda_pull` only while the bus clock is low. It pulls the data line low during the ninth clock of every byte that it accepts.
- R3: In a write, the host sends the address with R/W=0, then index N, then count X, then X data bytes. The target acknowledges each byte and stores the data bytes into registers N through N+X-1, with the index stepping by one after each data byte.
- R4: Data bytes beyond the count X are acknowledged and discarded. Writes that land on an index of 8 or above are acknowledged and discarded.
- R5: A read runs as follows: the host writes index N, issues a repeated start, and sends the address with R/W=1. The target then sends register 7 as a count byte, followed by bytes from index N upward, MSB first. It keeps sending while the host acknowledges. After a not-acknowledge it releases the data line.
- R6: The read map after reset is: reg0=0xFF, reg1={latched[1:0],6'b000110}, reg2=0xFF, reg3=0x5F, reg4=0xFF, reg5=0x01, reg6=0x02, reg7=0x08. Indices 8 and above read 0x00.
- R7: Only these bits can be written: reg0[2:1], reg1[5:3] and reg1[1:0], reg2[2:1], reg3[7:4], and reg7[4:0]. Every other bit keeps its fixed value, and registers 4 to 6 cannot be written.
- R8: `spread_mode` equals `spread_latched` while reg1[5]=0 and equals reg1[4:3] while reg1[5]=1. reg1[7:6] always reads `spread_latched`.
- R9: The outputs follow the registers as follows: `pair_oe[1]`=reg0[2], `pair_oe[0]`=reg0[1]; `amp_sel`=reg1[1:0]; `pair_fast_slew[1]`=reg2[2], `pair_fast_slew[0]`=reg2[1]; `ref_slew`=reg3[7:6]; `ref_wake`=reg3[5]; `ref_oe`=reg3[4].
- R10: A stop at any point returns the target to idle. Bytes already completed stay written, a partial byte is dropped, and the registers change only when a data byte is committed.
- R11: reg7 keeps only bits 4:0 of a written byte, and its bits 7:5 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset; `addr_sel` is captured while high |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_pull | output | 1 | 1 pulls the data line low (open-drain drive) |
| addr_sel | input | 1 | Bus address select, captured during reset |
| spread_latched | input | 2 | Spread code latched at power-up (read-only) |
| pair_oe | output | 2 | Output enable for clock pairs 1 and 0 |
| pair_fast_slew | output | 2 | Fast slew select for clock pairs 1 and 0 |
| amp_sel | output | 2 | Differential amplitude code (00=0.6 V … 11=0.9 V) |
| spread_mode | output | 2 | Spread code in effect |
| ref_slew | output | 2 | Reference output slew code |
| ref_wake | output | 1 | Keep reference running in power down |
| ref_oe | output | 1 | Reference output enable |

## Verification
The design reacts to a bus-clock edge three system clocks after it appears at `scl_in`: two synchronizer stages, then the edge-detect register. Acknowledge and read bits therefore settle well inside the eight-clock quarter period that the bench uses between line changes. The bench samples the data line in the middle of each bus-clock high phase. A write byte is committed at the clock fall that ends its eighth bit, and the register outputs change one system clock later. The bench checks port fields only after the stop condition, many cycles past that point. Any change of `sda_pull` while the clock is high is counted at every falling system-clock edge.

// File: rtl/smb_pkg.sv
package smb_pkg;

    localparam int BYTE_W     = 8;
    localparam int REG_COUNT  = 8;
    localparam int CNT_W      = 5;
    localparam int BIT_CNT_W  = $clog2(BYTE_W + 1);

    localparam logic [BYTE_W-1:0] RESERVED_BYTE = 8'hFF;
    localparam logic [BYTE_W-1:0] ID_REV_VENDOR = 8'h01;
    localparam logic [BYTE_W-1:0] ID_DEVICE     = 8'h02;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_RX_ACK,
        PH_TX,
        PH_TX_ACK
    } phase_t;

    typedef enum logic [1:0] {
        ROLE_ADDR,
        ROLE_INDEX,
        ROLE_COUNT,
        ROLE_DATA
    } role_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic [1:0]       pair_oe;
        logic             ss_sw_en;
        logic [1:0]       ss_sw_code;
        logic [1:0]       amp;
        logic [1:0]       pair_slew;
        logic [1:0]       ref_slew;
        logic             ref_wake;
        logic             ref_oe;
        logic [CNT_W-1:0] bcount;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{
        pair_oe:    2'b11,
        ss_sw_en:   1'b0,
        ss_sw_code: 2'b00,
        amp:        2'b10,
        pair_slew:  2'b11,
        ref_slew:   2'b01,
        ref_wake:   1'b0,
        ref_oe:     1'b1,
        bcount:     CNT_W'(8)
    };

    // Spread code in effect: software code once software control is on.
    function automatic logic [1:0] eff_spread(input cfg_t c, input logic [1:0] latched);
        return c.ss_sw_en ? c.ss_sw_code : latched;
    endfunction

    // Byte presented to the bus for a given index.
    function automatic logic [BYTE_W-1:0] read_map(input logic [BYTE_W-1:0] idx,
                                                   input cfg_t c,
                                                   input logic [1:0] latched);
        logic [BYTE_W-1:0] b;
        case (idx)
            8'd0:    b = {5'b11111, c.pair_oe, 1'b1};
            8'd1:    b = {latched, c.ss_sw_en, c.ss_sw_code, 1'b1, c.amp};
            8'd2:    b = {5'b11111, c.pair_slew, 1'b1};
            8'd3:    b = {c.ref_slew, c.ref_wake, c.ref_oe, 4'hF};
            8'd4:    b = RESERVED_BYTE;
            8'd5:    b = ID_REV_VENDOR;
            8'd6:    b = ID_DEVICE;
            8'd7:    b = {{(BYTE_W-CNT_W){1'b0}}, c.bcount};
            default: b = '0;
        endcase
        return b;
    endfunction

    // Apply one committed byte; fixed bits and unmapped indices are dropped.
    function automatic cfg_t write_map(input logic [BYTE_W-1:0] idx,
                                       input logic [BYTE_W-1:0] d,
                                       input cfg_t c);
        cfg_t n;
        n = c;
        case (idx)
            8'd0: n.pair_oe = d[2:1];
            8'd1: begin
                n.ss_sw_en   = d[5];
                n.ss_sw_code = d[4:3];
                n.amp        = d[1:0];
            end
            8'd2: n.pair_slew = d[2:1];
            8'd3: begin
                n.ref_slew = d[7:6];
                n.ref_wake = d[5];
                n.ref_oe   = d[4];
            end
            8'd7: n.bcount = d[CNT_W-1:0];
            default: n = c;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '1;
        else     pipe <= {pipe[STAGES-2:0], din};
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/smb_cond_detect.sv
module smb_cond_detect
    import smb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_s,
    input  logic    sda_s,
    output bus_ev_t ev
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        ev.rise  = scl_s & ~scl_q;
        ev.fall  = ~scl_s & scl_q;
        ev.start = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop  = scl_s & scl_q & ~sda_q & sda_s;
        ev.sda   = sda_s;
    end
endmodule

// File: rtl/smb_xfer_fsm.sv
module smb_xfer_fsm
    import smb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [6:0]        own_addr,
    input  logic [BYTE_W-1:0] cnt_byte,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic [BYTE_W-1:0] rd_idx,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sda_pull,
    output logic              busy
);
    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W);

    phase_t                phase;
    role_t                 role;
    logic [BYTE_W-1:0]     sh;
    logic [BIT_CNT_W-1:0]  bcnt;
    logic [BYTE_W-1:0]     idx;
    logic [BYTE_W-1:0]     left;
    logic                  rd_mode;
    logic                  first_tx;
    logic                  host_ack;
    logic [BYTE_W-1:0]     tx_byte;

    assign tx_byte = first_tx ? cnt_byte : rd_byte;
    assign rd_idx  = idx;
    assign busy    = (phase != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            role     <= ROLE_ADDR;
            sh       <= '0;
            bcnt     <= '0;
            idx      <= '0;
            left     <= '0;
            rd_mode  <= 1'b0;
            first_tx <= 1'b0;
            host_ack <= 1'b0;
            sda_pull <= 1'b0;
            wr_en    <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (ev.start) begin
                phase    <= PH_RX;
                role     <= ROLE_ADDR;
                bcnt     <= '0;
                sda_pull <= 1'b0;
            end else if (ev.stop) begin
                phase    <= PH_IDLE;
                sda_pull <= 1'b0;
            end else begin
                case (phase)
                    PH_RX: begin
                        if (ev.rise) begin
                            sh   <= {sh[BYTE_W-2:0], ev.sda};
                            bcnt <= bcnt + 1'b1;
                        end else if (ev.fall && bcnt == LAST_BIT) begin
                            bcnt     <= '0;
                            phase    <= PH_RX_ACK;
                            sda_pull <= 1'b1;
                            case (role)
                                ROLE_ADDR: begin
                                    if (sh[BYTE_W-1:1] == own_addr) begin
                                        rd_mode  <= sh[0];
                                        first_tx <= 1'b1;
                                        role     <= ROLE_INDEX;
                                    end else begin
                                        phase    <= PH_IDLE;
                                        sda_pull <= 1'b0;
                                    end
                                end
                                ROLE_INDEX: begin
                                    idx  <= sh;
                                    role <= ROLE_COUNT;
                                end
                                ROLE_COUNT: begin
                                    left <= sh;
                                    role <= ROLE_DATA;
                                end
                                default: begin
                                    if (left != '0) begin
                                        wr_en   <= 1'b1;
                                        wr_idx  <= idx;
                                        wr_data <= sh;
                                        idx     <= idx + 1'b1;
                                        left    <= left - 1'b1;
                                    end
                                end
                            endcase
                        end
                    end
                    PH_RX_ACK: begin
                        if (ev.fall) begin
                            if (rd_mode) begin
                                phase    <= PH_TX;
                                sh       <= tx_byte;
                                sda_pull <= ~tx_byte[BYTE_W-1];
                                first_tx <= 1'b0;
                                if (!first_tx) idx <= idx + 1'b1;
                            end else begin
                                phase    <= PH_RX;
                                sda_pull <= 1'b0;
                            end
                        end
                    end
                    PH_TX: begin
                        if (ev.rise) begin
                            bcnt <= bcnt + 1'b1;
                        end else if (ev.fall) begin
                            if (bcnt == LAST_BIT) begin
                                bcnt     <= '0;
                                sda_pull <= 1'b0;
                                phase    <= PH_TX_ACK;
                            end else begin
                                sh       <= {sh[BYTE_W-2:0], 1'b0};
                                sda_pull <= ~sh[BYTE_W-2];
                            end
                        end
                    end
                    PH_TX_ACK: begin
                        if (ev.rise) begin
                            host_ack <= ~ev.sda;
                        end else if (ev.fall) begin
                            if (host_ack) begin
                                phase    <= PH_TX;
                                sh       <= tx_byte;
                                sda_pull <= ~tx_byte[BYTE_W-1];
                                first_tx <= 1'b0;
                                if (!first_tx) idx <= idx + 1'b1;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/smb_cfg_regs.sv
module smb_cfg_regs
    import smb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [BYTE_W-1:0] rd_idx,
    input  logic [1:0]        spread_latched,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [BYTE_W-1:0] cnt_byte,
    output cfg_t              cfg
);
    always_ff @(posedge clk) begin
        if (rst)        cfg <= CFG_RESET;
        else if (wr_en) cfg <= write_map(wr_idx, wr_data, cfg);
    end

    assign rd_byte  = read_map(rd_idx, cfg, spread_latched);
    assign cnt_byte = read_map(BYTE_W'(REG_COUNT - 1), cfg, spread_latched);
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
    import smb_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] ADDR_SEL0   = 7'h68,
    parameter logic [6:0] ADDR_SEL1   = 7'h6A
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_pull,
    input  logic       addr_sel,
    input  logic [1:0] spread_latched,
    output logic [1:0] pair_oe,
    output logic [1:0] pair_fast_slew,
    output logic [1:0] amp_sel,
    output logic [1:0] spread_mode,
    output logic [1:0] ref_slew,
    output logic       ref_wake,
    output logic       ref_oe
);
    localparam int LINES = 2;

    logic [LINES-1:0]  raw_lines;
    logic [LINES-1:0]  sync_lines;
    bus_ev_t           ev;
    logic              sel_q;
    logic [6:0]        own_addr;
    logic [BYTE_W-1:0] rd_idx;
    logic [BYTE_W-1:0] rd_byte;
    logic [BYTE_W-1:0] cnt_byte;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_idx;
    logic [BYTE_W-1:0] wr_data;
    logic              fsm_busy;
    cfg_t              cfg;

    assign raw_lines = {sda_in, scl_in};

    for (genvar g = 0; g < LINES; g++) begin : g_sync
        smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst  (rst),
            .din  (raw_lines[g]),
            .dout (sync_lines[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) sel_q <= addr_sel;
    end

    assign own_addr = sel_q ? ADDR_SEL1 : ADDR_SEL0;

    smb_cond_detect u_det (
        .clk   (clk),
        .rst   (rst),
        .scl_s (sync_lines[0]),
        .sda_s (sync_lines[1]),
        .ev    (ev)
    );

    smb_xfer_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .own_addr (own_addr),
        .cnt_byte (cnt_byte),
        .rd_byte  (rd_byte),
        .rd_idx   (rd_idx),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .sda_pull (sda_pull),
        .busy     (fsm_busy)
    );

    smb_cfg_regs u_regs (
        .clk            (clk),
        .rst            (rst),
        .wr_en          (wr_en),
        .wr_idx         (wr_idx),
        .wr_data        (wr_data),
        .rd_idx         (rd_idx),
        .spread_latched (spread_latched),
        .rd_byte        (rd_byte),
        .cnt_byte       (cnt_byte),
        .cfg            (cfg)
    );

    assign pair_oe        = cfg.pair_oe;
    assign pair_fast_slew = cfg.pair_slew;
    assign amp_sel        = cfg.amp;
    assign spread_mode    = eff_spread(cfg, spread_latched);
    assign ref_slew       = cfg.ref_slew;
    assign ref_wake       = cfg.ref_wake;
    assign ref_oe         = cfg.ref_oe;
endmodule

// File: rtl/smb_cfg_slave_checker.sv
module smb_cfg_slave_checker
    import smb_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic scl_in,
    input logic sda_pull,
    input logic busy,
    input logic wr_en,
    input cfg_t cfg
);
    // R2: the data drive only moves while the bus clock is low
    assert_pull_scl_low_R2: assert property (@(posedge clk) disable iff (rst)
        (scl_in && $past(scl_in)) |-> $stable(sda_pull));

    // R5: no drive once the engine has returned to idle
    assert_idle_release_R5: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sda_pull);

    // R10: configuration moves only after a committed byte
    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en) |-> $stable(cfg));

    // R3: one commit per received byte
    assert_commit_single_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);
endmodule

bind smb_cfg_slave smb_cfg_slave_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_in   (scl_in),
    .sda_pull (sda_pull),
    .busy     (fsm_busy),
    .wr_en    (wr_en),
    .cfg      (cfg)
);

// File: tb/smb_cfg_slave_bench.sv
module smb_cfg_slave_bench;
    localparam int Q = 8;
    localparam logic [6:0] ADDR0 = 7'h68;
    localparam logic [6:0] ADDR1 = 7'h6A;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst = 1'b1;
    logic       scl_drv = 1'b1;
    logic       sda_host = 1'b1;
    logic       addr_sel = 1'b0;
    logic [1:0] latched = 2'b01;
    logic       sda_pull;
    logic [1:0] pair_oe, pair_fast_slew, amp_sel, spread_mode, ref_slew;
    logic       ref_wake, ref_oe;
    wire        sda_line = sda_host & ~sda_pull;

    smb_cfg_slave u_smb_cfg_slave (
        .clk(clk), .rst(rst), .scl_in(scl_drv), .sda_in(sda_line), .sda_pull(sda_pull),
        .addr_sel(addr_sel), .spread_latched(latched), .pair_oe(pair_oe),
        .pair_fast_slew(pair_fast_slew), .amp_sel(amp_sel), .spread_mode(spread_mode),
        .ref_slew(ref_slew), .ref_wake(ref_wake), .ref_oe(ref_oe)
    );

    int checks = 0;
    int fails = 0;
    int r2_err = 0;
    bit done = 1'b0;
    logic [7:0] wbuf [0:15];
    logic [7:0] rbuf [0:15];
    logic prev_scl = 1'b1;
    logic prev_pull = 1'b0;

    // R2 monitor: count drive changes while the clock stays high
    always @(negedge clk) begin
        if (!rst && scl_drv && prev_scl && (sda_pull != prev_pull)) r2_err <= r2_err + 1;
        prev_scl  <= scl_drv;
        prev_pull <= sda_pull;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic sel);
        rst = 1'b1; addr_sel = sel; scl_drv = 1'b1; sda_host = 1'b1;
        tick(5);
        rst = 1'b0;
        tick(5);
    endtask

    task automatic bus_start();
        sda_host = 1'b1; tick(Q);
        scl_drv = 1'b1;  tick(Q);
        sda_host = 1'b0; tick(Q);
        scl_drv = 1'b0;  tick(Q);
    endtask

    task automatic bus_stop();
        sda_host = 1'b0; tick(Q);
        scl_drv = 1'b1;  tick(Q);
        sda_host = 1'b1; tick(Q);
    endtask

    task automatic bus_bit(input logic v, output logic seen);
        sda_host = v;   tick(Q);
        scl_drv = 1'b1; tick(Q);
        seen = sda_line; tick(Q);
        scl_drv = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
        bus_bit(1'b1, s);
        acked = (s == 1'b0);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, s);
            b[i] = s;
        end
        bus_bit(~give_ack, s);
    endtask

    task automatic wr_txn(input logic [6:0] a, input logic [7:0] idx, input logic [7:0] cnt,
                          input int n, output logic all_ack);
        logic k;
        all_ack = 1'b1;
        bus_start();
        send_byte({a, 1'b0}, k); all_ack &= k;
        send_byte(idx, k);       all_ack &= k;
        send_byte(cnt, k);       all_ack &= k;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], k); all_ack &= k;
        end
        bus_stop();
        tick(4);
    endtask

    // rbuf[0] = count byte, rbuf[1..n] = data
    task automatic rd_txn(input logic [6:0] a, input logic [7:0] idx, input int n,
                          output logic all_ack, output logic released);
        logic k;
        all_ack = 1'b1;
        bus_start();
        send_byte({a, 1'b0}, k); all_ack &= k;
        send_byte(idx, k);       all_ack &= k;
        bus_start();
        send_byte({a, 1'b1}, k); all_ack &= k;
        recv_byte(1'b1, rbuf[0]);
        for (int i = 1; i <= n; i++) recv_byte(i < n, rbuf[i]);
        tick(Q);
        released = ~sda_pull;
        bus_stop();
        tick(4);
    endtask

    task automatic t_reset();
        logic ok, rel;
        logic [7:0] e [0:8];
        check_eq("R6 reset pair_oe", pair_oe, 2'b11);
        check_eq("R6 reset amp_sel", amp_sel, 2'b10);
        check_eq("R6 reset pair_fast_slew", pair_fast_slew, 2'b11);
        check_eq("R6 reset ref fields", {ref_slew, ref_wake, ref_oe}, 4'b0101);
        check_eq("R8 reset spread follows latch", spread_mode, 2'b01);
        check_eq("R2 no drive at idle", sda_pull, 1'b0);
        e = '{8'hFF, 8'h46, 8'hFF, 8'h5F, 8'hFF, 8'h01, 8'h02, 8'h08, 8'h00};
        rd_txn(ADDR0, 8'd0, 9, ok, rel);
        check_eq("R5 read acks", ok, 1'b1);
        check_eq("R5 count byte first", rbuf[0], 8'h08);
        for (int i = 0; i < 9; i++) check_eq("R6 reset read map", rbuf[i+1], e[i]);
        check_eq("R5 release after nack", rel, 1'b1);
    endtask

    task automatic t_write_fields();
        logic ok, rel;
        wbuf[0] = 8'hF9; wbuf[1] = 8'h01; wbuf[2] = 8'h02; wbuf[3] = 8'h90;
        wr_txn(ADDR0, 8'd0, 8'd4, 4, ok);
        check_eq("R3 write acks", ok, 1'b1);
        check_eq("R9 pair_oe", pair_oe, 2'b00);
        check_eq("R9 amp_sel", amp_sel, 2'b01);
        check_eq("R9 pair_fast_slew", pair_fast_slew, 2'b01);
        check_eq("R9 ref fields", {ref_slew, ref_wake, ref_oe}, 4'b1001);
        rd_txn(ADDR0, 8'd0, 4, ok, rel);
        check_eq("R3 readback reg0", rbuf[1], 8'hF9);
        check_eq("R3 readback reg1", rbuf[2], 8'h45);
        check_eq("R3 readback reg2", rbuf[3], 8'hFB);
        check_eq("R3 readback reg3", rbuf[4], 8'h9F);
    endtask

    task automatic t_readonly();
        logic ok, rel;
        wbuf[0] = 8'h00;
        wr_txn(ADDR0, 8'd0, 8'd1, 1, ok);
        rd_txn(ADDR0, 8'd0, 1, ok, rel);
        check_eq("R7 reg0 fixed bits", rbuf[1], 8'hF9);
        wbuf[0] = 8'h00; wbuf[1] = 8'h55; wbuf[2] = 8'hAA;
        wr_txn(ADDR0, 8'd4, 8'd3, 3, ok);
        check_eq("R7 read-only writes acked", ok, 1'b1);
        rd_txn(ADDR0, 8'd4, 3, ok, rel);
        check_eq("R7 reg4 fixed", rbuf[1], 8'hFF);
        check_eq("R7 reg5 fixed", rbuf[2], 8'h01);
        check_eq("R7 reg6 fixed", rbuf[3], 8'h02);
        wbuf[0] = 8'hFF;
        wr_txn(ADDR0, 8'd7, 8'd1, 1, ok);
        rd_txn(ADDR0, 8'd7, 1, ok, rel);
        check_eq("R11 count byte top bits zero", rbuf[0], 8'h1F);
        check_eq("R11 reg7 readback", rbuf[1], 8'h1F);
        wbuf[0] = 8'hE8;
        wr_txn(ADDR0, 8'd7, 8'd1, 1, ok);
        rd_txn(ADDR0, 8'd7, 1, ok, rel);
        check_eq("R11 reg7 keeps low five bits", rbuf[1], 8'h08);
    endtask

    task automatic t_spread();
        logic ok, rel;
        wbuf[0] = 8'h38;
        wr_txn(ADDR0, 8'd1, 8'd1, 1, ok);
        check_eq("R8 software spread code", spread_mode, 2'b11);
        check_eq("R9 amp after reg1 write", amp_sel, 2'b00);
        rd_txn(ADDR0, 8'd1, 1, ok, rel);
        check_eq("R8 reg1 readback", rbuf[1], 8'h7C);
        latched = 2'b10;
        tick(4);
        rd_txn(ADDR0, 8'd1, 1, ok, rel);
        check_eq("R8 latched readback live", rbuf[1], 8'hBC);
        check_eq("R8 software keeps control", spread_mode, 2'b11);
        wbuf[0] = 8'h18;
        wr_txn(ADDR0, 8'd1, 8'd1, 1, ok);
        check_eq("R8 back to latched code", spread_mode, 2'b10);
    endtask

    task automatic t_overrun();
        logic ok;
        wbuf[0] = 8'hFF; wbuf[1] = 8'h03;
        wr_txn(ADDR0, 8'd0, 8'd1, 2, ok);
        check_eq("R4 excess byte acked", ok, 1'b1);
        check_eq("R4 counted byte stored", pair_oe, 2'b11);
        check_eq("R4 excess byte discarded", amp_sel, 2'b00);
        wbuf[0] = 8'h03;
        wr_txn(ADDR0, 8'd9, 8'd1, 1, ok);
        check_eq("R4 high index acked", ok, 1'b1);
        check_eq("R4 high index discarded", amp_sel, 2'b00);
    endtask

    task automatic t_stop_abort();
        logic ok, k, s;
        bus_start();
        send_byte({ADDR0, 1'b0}, k);
        send_byte(8'd2, k);
        send_byte(8'd2, k);
        send_byte(8'hF9, k);
        for (int i = 0; i < 4; i++) bus_bit(1'b0, s);
        bus_stop();
        tick(4);
        check_eq("R10 committed byte kept", pair_fast_slew, 2'b00);
        check_eq("R10 partial byte dropped", {ref_slew, ref_wake, ref_oe}, 4'b1001);
        check_eq("R10 idle after stop", sda_pull, 1'b0);
        rd_txn(ADDR0, 8'd2, 2, ok, k);
        check_eq("R10 transfer after abort", ok, 1'b1);
        check_eq("R10 reg2 readback", rbuf[1], 8'hF9);
        check_eq("R10 reg3 readback", rbuf[2], 8'h9F);
    endtask

    task automatic t_mismatch();
        logic ok;
        wbuf[0] = 8'h00;
        wr_txn(ADDR1, 8'd0, 8'd1, 1, ok);
        check_eq("R1 foreign address not acked", ok, 1'b0);
        check_eq("R1 foreign write ignored", pair_oe, 2'b11);
    endtask

    task automatic t_addr_sel();
        logic ok;
        do_reset(1'b1);
        wbuf[0] = 8'hF9;
        wr_txn(ADDR0, 8'd0, 8'd1, 1, ok);
        check_eq("R1 low address refused", ok, 1'b0);
        check_eq("R1 low address write ignored", pair_oe, 2'b11);
        wr_txn(ADDR1, 8'd0, 8'd1, 1, ok);
        check_eq("R1 high address acked", ok, 1'b1);
        check_eq("R1 high address write", pair_oe, 2'b00);
    endtask

    initial begin
        do_reset(1'b0);
        t_reset();
        t_write_fields();
        t_readonly();
        t_spread();
        t_overrun();
        t_stop_abort();
        t_mismatch();
        t_addr_sel();
        check_eq("R2 drive changed with clock high", r2_err, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule